// File: doc/BRIEF.md
# Word FIFO with DMA Request Thresholds

This block is a first-in first-out store of 32-bit words. It sits between a bus-side writer and an output channel that reads from it. The writer is a processor or a DMA engine, and it offers words on a valid/ready push port. The output channel takes words on a pop port. Each pop returns the oldest stored word on a registered data output. If the store is empty, the pop returns the word that was read last.

The block drives a status vector with the fill level, full and empty flags, and two sticky error flags. One error flag marks a push that was refused because the store was full. The other marks a pop that found the store empty. A separate pulse input discards the whole contents at once.

Two request lines tell the DMA engine when to refill. Each line compares the fill level with its own 8-bit threshold taken from a configuration word. Both lines are forced low while the enable bit of that word is clear.

Top module: `pwm_word_fifo`

## Requirements
- R1: Popped words leave in the order they were pushed, full 32 bits wide. The store holds up to 16 words. A popped word appears on `pop_data` one clock after the pop is accepted.
- R2: `level` counts the stored words, from 0 to 16. `full` is 1 exactly when `level` is 16. `empty` is 1 exactly when `level` is 0. After reset: `level` = 0, `empty` = 1, `pop_data` = 0, and every flag and request line is 0.
- R3: A push offered while `full` is 1 is dropped and leaves `level` unchanged. It sets `werr`. `werr` stays at 1 until a cycle with `werr_clr` = 1 and no new refused push.
- R4: A pop requested while `empty` is 1 leaves `pop_data` holding the last word read. It sets `rerr`. `rerr` stays at 1 until a cycle with `rerr_clr` = 1 and no new failed pop.
- R5: A cycle with `fifo_clr` = 1 empties the store. Any push or pop in that same cycle is discarded and sets no error flag. The clear has no effect on `werr` or `rerr`. A cycle with `fifo_clr` = 0 does not clear anything.
- R6: `dreq` is 1 exactly when `dma_cfg[31]` = 1 and `level` ≤ `dma_cfg[7:0]`.
- R7: `panic` is 1 exactly when `dma_cfg[31]` = 1 and `level` ≤ `dma_cfg[15:8]`.
- R8: A push and a pop accepted in the same cycle, with the store neither full nor empty, leave `level` unchanged and keep the word order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Writer offers a word |
| push_data | input | 32 | Word offered by the writer |
| push_ready | output | 1 | Store can take a word this cycle |
| pop_req | input | 1 | Channel requests the next word |
| pop_data | output | 32 | Last word popped |
| fifo_clr | input | 1 | Pulse that discards the whole contents |
| werr_clr | input | 1 | Pulse that clears the refused-push flag |
| rerr_clr | input | 1 | Pulse that clears the failed-pop flag |
| dma_cfg | input | 32 | DMA configuration: request threshold in [7:0], urgent threshold in [15:8], enable in [31] |
| level | output | 5 | Number of stored words |
| full | output | 1 | Store is full |
| empty | output | 1 | Store is empty |
| werr | output | 1 | Sticky flag: a push was refused because the store was full |
| rerr | output | 1 | Sticky flag: a pop found the store empty |
| dreq | output | 1 | DMA refill request |
| panic | output | 1 | Urgent DMA refill request |

## Verification
The hardest case is the boundary at full, when a push and a pop arrive in the same cycle. The pop must be accepted and the push refused, because the push is judged against the full state at the start of the cycle. To reach it, the bench fills the store to exactly 16 words, then offers both a push and a pop in one cycle. A queue model predicts which word leaves and that the offered word never comes out. The clear pulse is also given together with a push and a pop, to show that neither is taken and that no error flag is raised.

// File: rtl/pwm_word_fifo.sv
module pwm_word_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int TW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  output logic          push_ready,
  input  logic          pop_req,
  output logic [DW-1:0] pop_data,
  input  logic          fifo_clr,
  input  logic          werr_clr,
  input  logic          rerr_clr,
  input  logic [31:0]   dma_cfg,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          werr,
  output logic          rerr,
  output logic          dreq,
  output logic          panic
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop, bad_push, bad_pop;
  logic [TW-1:0] dreq_th, panic_th;
  logic          dma_en;

  assign full       = (level == LW'(DEPTH));
  assign empty      = (level == '0);
  assign push_ready = !full && !fifo_clr;

  assign do_push  = push_valid && !full  && !fifo_clr;
  assign do_pop   = pop_req    && !empty && !fifo_clr;
  assign bad_push = push_valid &&  full  && !fifo_clr;
  assign bad_pop  = pop_req    &&  empty && !fifo_clr;

  assign dreq_th  = dma_cfg[TW-1:0];
  assign panic_th = dma_cfg[2*TW-1:TW];
  assign dma_en   = dma_cfg[31];

  assign dreq  = dma_en && (32'(level) <= 32'(dreq_th));
  assign panic = dma_en && (32'(level) <= 32'(panic_th));

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      level    <= '0;
      pop_data <= '0;
    end else if (fifo_clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop) begin
        rd_ptr   <= rd_ptr + AW'(1);
        pop_data <= mem[rd_ptr];
      end
      case ({do_push, do_pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      werr <= 1'b0;
      rerr <= 1'b0;
    end else begin
      if (bad_push)      werr <= 1'b1;
      else if (werr_clr) werr <= 1'b0;
      if (bad_pop)       rerr <= 1'b1;
      else if (rerr_clr) rerr <= 1'b0;
    end
  end

endmodule

// File: rtl/pwm_word_fifo_chk.sv
module pwm_word_fifo_chk #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_valid,
  input logic          pop_req,
  input logic [DW-1:0] pop_data,
  input logic          fifo_clr,
  input logic          werr_clr,
  input logic          rerr_clr,
  input logic [31:0]   dma_cfg,
  input logic [LW-1:0] level,
  input logic          full,
  input logic          empty,
  input logic          werr,
  input logic          rerr,
  input logic          dreq,
  input logic          panic
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) 32'(level) <= DEPTH); // R2
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(full && empty)); // R2
  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full && push_valid && !pop_req && !fifo_clr |=> level == $past(level)); // R3
  AST_WERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) werr && !werr_clr |=> werr); // R3
  AST_RERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) rerr && !rerr_clr |=> rerr); // R4
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop_req && !fifo_clr |=> $stable(pop_data)); // R4
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) fifo_clr |=> empty); // R5
  AST_CLEAR_KEEPS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr && !werr_clr && !rerr_clr |=> werr == $past(werr) && rerr == $past(rerr)); // R5
  AST_DREQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) !dma_cfg[31] |-> !dreq); // R6
  AST_PANIC_GATED: assert property (@(posedge clk) disable iff (!rst_n) !dma_cfg[31] |-> !panic); // R7
  AST_PUSH_POP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && pop_req && !full && !empty && !fifo_clr |=> $stable(level)); // R8

endmodule

bind pwm_word_fifo pwm_word_fifo_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .pop_req(pop_req),
  .pop_data(pop_data), .fifo_clr(fifo_clr), .werr_clr(werr_clr), .rerr_clr(rerr_clr),
  .dma_cfg(dma_cfg), .level(level), .full(full), .empty(empty), .werr(werr),
  .rerr(rerr), .dreq(dreq), .panic(panic)
);

// File: tb/sim_pwm_word_fifo.sv
module sim_pwm_word_fifo;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0;
  logic [31:0] push_data = '0;
  logic        push_ready;
  logic        pop_req = 1'b0;
  logic [31:0] pop_data;
  logic        fifo_clr = 1'b0;
  logic        werr_clr = 1'b0;
  logic        rerr_clr = 1'b0;
  logic [31:0] dma_cfg = '0;
  logic [4:0]  level;
  logic        full, empty, werr, rerr, dreq, panic;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_word_fifo u0 (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .push_ready(push_ready), .pop_req(pop_req), .pop_data(pop_data),
    .fifo_clr(fifo_clr), .werr_clr(werr_clr), .rerr_clr(rerr_clr),
    .dma_cfg(dma_cfg), .level(level), .full(full), .empty(empty),
    .werr(werr), .rerr(rerr), .dreq(dreq), .panic(panic)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] sb_q[$];
  logic [31:0] sb_exp;
  bit          sb_chk;
  int          sb_n;

  always @(posedge clk) begin
    sb_chk = 1'b0;
    if (rst_n) begin
      sb_n = sb_q.size();
      if (fifo_clr) sb_q.delete();
      else begin
        if (pop_req && sb_n > 0) begin
          sb_exp = sb_q.pop_front();
          sb_chk = 1'b1;
        end
        if (push_valid && sb_n < DEPTH) sb_q.push_back(push_data);
      end
    end
    if (sb_chk) begin
      #2;
      check(pop_data == sb_exp, "R1 pop order", pop_data, sb_exp);
    end
  end

  task automatic push(input logic [31:0] d);
    push_valid = 1'b1; push_data = d;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic pop();
    pop_req = 1'b1;
    @(negedge clk);
    pop_req = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    check(level == 0 && empty && !full && !werr && !rerr && !dreq && !panic, "R2 reset flags",
          {level, empty, full, werr, rerr, dreq, panic}, {5'd0, 6'b100000});
    check(pop_data == 0, "R2 reset data", pop_data, 0);

    // R4 pop when empty
    pop();
    check(rerr && pop_data == 0, "R4 empty pop", {rerr, pop_data[30:0]}, 32'h8000_0000);
    rerr_clr = 1'b1; @(negedge clk); rerr_clr = 1'b0;
    check(!rerr, "R4 rerr clear", rerr, 0);

    // R1 R2 fill to full
    for (int i = 0; i < DEPTH; i++) push(32'hA500_0000 + i);
    check(full && !empty && level == 16 && !push_ready, "R2 full", {full, empty, level}, {2'b10, 5'd16});

    // R3 push while full
    push(32'hDEAD_BEEF);
    check(werr && level == 16, "R3 refused push", {werr, level}, {1'b1, 5'd16});
    @(negedge clk);
    check(werr, "R3 werr sticky", werr, 1);

    // full boundary: push and pop together -> pop taken, push dropped
    push_valid = 1'b1; push_data = 32'h0BAD_0BAD; pop_req = 1'b1;
    @(negedge clk);
    push_valid = 1'b0; pop_req = 1'b0;
    check(level == 15, "R3 push+pop at full", level, 15);

    // R1 drain
    for (int i = 1; i < DEPTH; i++) pop();
    check(empty && level == 0, "R2 empty after drain", level, 0);
    pop();
    check(rerr && pop_data == 32'hA500_000F, "R4 hold last word", pop_data, 32'hA500_000F);
    werr_clr = 1'b1; rerr_clr = 1'b1; @(negedge clk); werr_clr = 1'b0; rerr_clr = 1'b0;
    check(!werr && !rerr, "R3 R4 error clears", {werr, rerr}, 0);

    // R8 push and pop together mid-level
    push(32'h1111_0001); push(32'h1111_0002);
    for (int i = 3; i < 7; i++) begin
      push_valid = 1'b1; push_data = 32'h1111_0000 + i; pop_req = 1'b1;
      @(negedge clk);
      check(level == 2, "R8 level stable", level, 2);
    end
    push_valid = 1'b0; pop_req = 1'b0;
    pop(); pop();

    // R5 clear, error flags untouched
    pop();
    check(rerr, "R5 rerr set before clear", rerr, 1);
    rerr_clr = 1'b0;
    for (int i = 0; i < 5; i++) push(32'h2222_0000 + i);
    fifo_clr = 1'b1; push_valid = 1'b1; push_data = 32'h3333_3333; pop_req = 1'b1;
    @(negedge clk);
    fifo_clr = 1'b0; push_valid = 1'b0; pop_req = 1'b0;
    check(empty && level == 0, "R5 clear empties", level, 0);
    check(rerr && !werr, "R5 errors kept", {werr, rerr}, 1);
    @(negedge clk);
    check(empty, "R5 zero clear idle", empty, 1);
    rerr_clr = 1'b1; @(negedge clk); rerr_clr = 1'b0;
    push(32'h4444_0001); pop();

    // R6 R7 thresholds: dreq at [7:0]=4, panic at [15:8]=2, enable [31]
    dma_cfg = 32'h0000_0204;
    @(negedge clk);
    check(!dreq && !panic, "R6 R7 disabled", {dreq, panic}, 0);
    dma_cfg = 32'h8000_0204;
    @(negedge clk);
    check(dreq && panic, "R6 R7 level 0", {dreq, panic}, 3);
    for (int i = 1; i <= 6; i++) begin
      push(32'h5555_0000 + i);
      check(dreq == (i <= 4), "R6 dreq threshold", dreq, (i <= 4));
      check(panic == (i <= 2), "R7 panic threshold", panic, (i <= 2));
    end
    for (int i = 0; i < 6; i++) pop();
    check(empty && !rerr, "R2 final empty", {empty, rerr}, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule